// File: doc/BRIEF.md
# Reserved-Slot Input Buffer Admission

This block decides, on the receiving side of a node, whether each incoming network transaction may enter the node's input buffer. Requests and replies are held in two independent queues. Request space is split into fixed per-source shares of `K` slots, one share for each other node, so the request queue is sized at `K*(NODES-1)` entries. The reply queue holds `K` entries, which is the reply space for the node's own outstanding requests. Because of this split, a full request queue can never block a reply, and the node cannot fall into fetch deadlock.

A request that finds its source's share exhausted is not dropped and is not stalled. The block answers it with a negative acknowledgement that carries the sender's ID and the request tag. The sender treats that answer as a reply and can always absorb it in its own reserved reply space. When the local consumer removes a request, a one-cycle credit pulse names the source whose slot became free. Refused requests wait in a small queue in front of the NACK port, so that a refusal is never lost while the port is busy.

Top module: `rsv_inbuf_admit`

## Requirements
- R1: After synchronous reset both dequeue ports show no valid entry, `nack_valid` and `rep_overflow_err` are 0, and `in_accept` is 1.
- R2: A request (`in_is_reply`=0) whose source holds fewer than `K` undequeued entries is accepted and enqueued. From the next cycle it appears on the request dequeue port with the same source, tag and payload. Requests leave in arrival order.
- R3: A request whose source already holds `K` undequeued entries is not enqueued. In the cycle after it is taken, `nack_valid` is 1 with `nack_src` and `nack_tag` equal to the refused request's source and tag.
- R4: A request from source `SELF_ID` has no share and is always refused with a NACK.
- R5: In every cycle in which a request entry is dequeued (`req_deq_valid` and `req_deq_ready`), `credit_valid` is 1 and `credit_src` equals that entry's source. The slot counts as free from the following cycle.
- R6: A reply (`in_is_reply`=1) is always accepted (`in_accept`=1), whatever the state of the request queue.
- R7: The reply queue holds `K` entries. A reply that arrives while it is full is discarded and sets `rep_overflow_err`, which stays 1 until reset.
- R8: Refused requests queue for the NACK port in up to `NACK_DEPTH` entries, in arrival order. While that queue is full, a request that would be refused sees `in_accept`=0 and is not consumed.
- R9: Dequeuing replies does not change the head of the request queue, and the reverse also holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Incoming transaction present |
| in_is_reply | input | 1 | 1 = reply class, 0 = request class |
| in_src | input | SW | Sending node ID |
| in_tag | input | TAGW | Transaction tag |
| in_payload | input | PW | Transaction payload |
| in_accept | output | 1 | Transaction consumed this cycle when in_valid is 1 |
| nack_valid | output | 1 | NACK waiting to be sent |
| nack_ready | input | 1 | NACK taken by the network side |
| nack_src | output | SW | Node that receives the NACK |
| nack_tag | output | TAGW | Tag of the refused request |
| credit_valid | output | 1 | One-cycle credit return pulse |
| credit_src | output | SW | Node whose request slot was freed |
| req_deq_valid | output | 1 | Request queue not empty |
| req_deq_ready | input | 1 | Consumer takes head request |
| req_deq_src | output | SW | Head request source |
| req_deq_tag | output | TAGW | Head request tag |
| req_deq_payload | output | PW | Head request payload |
| rep_deq_valid | output | 1 | Reply queue not empty |
| rep_deq_ready | input | 1 | Consumer takes head reply |
| rep_deq_src | output | SW | Head reply source |
| rep_deq_tag | output | TAGW | Head reply tag |
| rep_deq_payload | output | PW | Head reply payload |
| rep_overflow_err | output | 1 | Sticky reply protocol violation flag |

## Verification
A wrong per-source count shows up one cycle after the next request from that source. The request is then either NACKed while its share still has room, or enqueued after the share is exhausted, and the bench sees this on `nack_valid` and in the number of entries it can drain. A missing or misdirected credit shows up on `credit_src` in the same cycle as the dequeue. Slot leaks show up when a refill after a drain is refused. Reply isolation faults show up at once on `in_accept` or when the reply queue is drained while the request queue is full.

// File: rtl/inbuf_pkg.sv
package inbuf_pkg;

    typedef enum logic {
        KIND_REQ = 1'b0,
        KIND_REP = 1'b1
    } msg_kind_e;

    function automatic int idx_w(input int n);
        return (n <= 2) ? 1 : $clog2(n);
    endfunction

endpackage

// File: rtl/inbuf_fifo.sv
module inbuf_fifo #(
    parameter int W     = 8,
    parameter int DEPTH = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         push,
    input  logic [W-1:0] din,
    input  logic         pop,
    output logic [W-1:0] dout,
    output logic         full,
    output logic         empty
);
    import inbuf_pkg::*;

    localparam int AW = idx_w(DEPTH);
    localparam int CW = $clog2(DEPTH + 1);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wptr, rptr;
    logic [CW-1:0] cnt;

    wire do_push = push && !full;
    wire do_pop  = pop && !empty;

    assign full  = (cnt == CW'(DEPTH));
    assign empty = (cnt == '0);
    assign dout  = mem[rptr];

    always_ff @(posedge clk) begin
        if (rst) begin
            wptr <= '0;
            rptr <= '0;
            cnt  <= '0;
        end else begin
            if (do_push) begin
                mem[wptr] <= din;
                wptr <= (wptr == AW'(DEPTH - 1)) ? '0 : wptr + 1'b1;
            end
            if (do_pop)
                rptr <= (rptr == AW'(DEPTH - 1)) ? '0 : rptr + 1'b1;
            case ({do_push, do_pop})
                2'b10:   cnt <= cnt + 1'b1;
                2'b01:   cnt <= cnt - 1'b1;
                default: cnt <= cnt;
            endcase
        end
    end

    // Occupancy never exceeds the depth (supports R2, R7, R8)
    assert_fifo_bound_R2: assert property (@(posedge clk) disable iff (rst)
        cnt <= CW'(DEPTH));

endmodule

// File: rtl/inbuf_share_ctr.sv
module inbuf_share_ctr #(
    parameter int NODES   = 4,
    parameter int K       = 2,
    parameter int SW      = 2,
    parameter int SELF_ID = 0
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          inc,
    input  logic [SW-1:0] inc_src,
    input  logic          dec,
    input  logic [SW-1:0] dec_src,
    output logic [NODES-1:0] has_room
);
    localparam int CW = $clog2(K + 1);

    for (genvar i = 0; i < NODES; i++) begin : g_share
        logic [CW-1:0] cnt;
        wire up = inc && (int'(inc_src) == i);
        wire dn = dec && (int'(dec_src) == i);

        always_ff @(posedge clk) begin
            if (rst)
                cnt <= '0;
            else if (up && !dn)
                cnt <= cnt + 1'b1;
            else if (dn && !up)
                cnt <= cnt - 1'b1;
        end

        if (i == SELF_ID) begin : g_self
            assign has_room[i] = 1'b0;
        end else begin : g_peer
            assign has_room[i] = (cnt < CW'(K));
        end

        // A share never holds more than K entries
        assert_share_cap_R2: assert property (@(posedge clk) disable iff (rst)
            cnt <= CW'(K));
        // A freed slot always belonged to an admitted entry
        assert_no_underflow_R5: assert property (@(posedge clk) disable iff (rst)
            (dn && !up) |-> (cnt != '0));
    end

endmodule

// File: rtl/rsv_inbuf_admit.sv
module rsv_inbuf_admit #(
    parameter int NODES      = 4,
    parameter int K          = 2,
    parameter int PW         = 8,
    parameter int TAGW       = 4,
    parameter int SELF_ID    = 0,
    parameter int NACK_DEPTH = 2,
    parameter int SW         = inbuf_pkg::idx_w(NODES)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            in_valid,
    input  logic            in_is_reply,
    input  logic [SW-1:0]   in_src,
    input  logic [TAGW-1:0] in_tag,
    input  logic [PW-1:0]   in_payload,
    output logic            in_accept,
    output logic            nack_valid,
    input  logic            nack_ready,
    output logic [SW-1:0]   nack_src,
    output logic [TAGW-1:0] nack_tag,
    output logic            credit_valid,
    output logic [SW-1:0]   credit_src,
    output logic            req_deq_valid,
    input  logic            req_deq_ready,
    output logic [SW-1:0]   req_deq_src,
    output logic [TAGW-1:0] req_deq_tag,
    output logic [PW-1:0]   req_deq_payload,
    output logic            rep_deq_valid,
    input  logic            rep_deq_ready,
    output logic [SW-1:0]   rep_deq_src,
    output logic [TAGW-1:0] rep_deq_tag,
    output logic [PW-1:0]   rep_deq_payload,
    output logic            rep_overflow_err
);
    import inbuf_pkg::*;

    localparam int REQ_DEPTH = K * (NODES - 1);

    typedef struct packed {
        logic [SW-1:0]   src;
        logic [TAGW-1:0] tag;
        logic [PW-1:0]   pl;
    } entry_t;

    typedef struct packed {
        logic [SW-1:0]   src;
        logic [TAGW-1:0] tag;
    } nack_t;

    msg_kind_e kind;
    entry_t    in_ent, req_head, rep_head;
    nack_t     nack_in, nack_head;
    logic [NODES-1:0] has_room;
    logic src_room, req_full, req_empty, rep_full, rep_empty, nk_full, nk_empty;
    logic is_req, is_rep, req_push, nack_push, rep_push, req_pop, rep_pop;

    assign kind     = in_is_reply ? KIND_REP : KIND_REQ;
    assign is_req   = in_valid && (kind == KIND_REQ);
    assign is_rep   = in_valid && (kind == KIND_REP);
    assign src_room = (int'(in_src) < NODES) && has_room[in_src];

    assign in_ent   = '{src: in_src, tag: in_tag, pl: in_payload};
    assign nack_in  = '{src: in_src, tag: in_tag};

    assign req_push  = is_req && src_room;
    assign nack_push = is_req && !src_room && !nk_full;
    assign rep_push  = is_rep && !rep_full;
    assign in_accept = !(is_req && !src_room && nk_full);

    assign req_pop = req_deq_ready && !req_empty;
    assign rep_pop = rep_deq_ready && !rep_empty;

    inbuf_share_ctr #(.NODES(NODES), .K(K), .SW(SW), .SELF_ID(SELF_ID)) share_i (
        .clk(clk), .rst(rst),
        .inc(req_push), .inc_src(in_src),
        .dec(req_pop),  .dec_src(req_head.src),
        .has_room(has_room)
    );

    inbuf_fifo #(.W($bits(entry_t)), .DEPTH(REQ_DEPTH)) reqq_i (
        .clk(clk), .rst(rst), .push(req_push), .din(in_ent),
        .pop(req_pop), .dout(req_head), .full(req_full), .empty(req_empty)
    );

    inbuf_fifo #(.W($bits(entry_t)), .DEPTH(K)) repq_i (
        .clk(clk), .rst(rst), .push(rep_push), .din(in_ent),
        .pop(rep_pop), .dout(rep_head), .full(rep_full), .empty(rep_empty)
    );

    inbuf_fifo #(.W($bits(nack_t)), .DEPTH(NACK_DEPTH)) nackq_i (
        .clk(clk), .rst(rst), .push(nack_push), .din(nack_in),
        .pop(nack_ready && !nk_empty), .dout(nack_head), .full(nk_full), .empty(nk_empty)
    );

    always_ff @(posedge clk) begin
        if (rst)
            rep_overflow_err <= 1'b0;
        else if (is_rep && rep_full)
            rep_overflow_err <= 1'b1;
    end

    assign nack_valid      = !nk_empty;
    assign nack_src        = nack_head.src;
    assign nack_tag        = nack_head.tag;
    assign credit_valid    = req_pop;
    assign credit_src      = req_head.src;
    assign req_deq_valid   = !req_empty;
    assign req_deq_src     = req_head.src;
    assign req_deq_tag     = req_head.tag;
    assign req_deq_payload = req_head.pl;
    assign rep_deq_valid   = !rep_empty;
    assign rep_deq_src     = rep_head.src;
    assign rep_deq_tag     = rep_head.tag;
    assign rep_deq_payload = rep_head.pl;

    // Share accounting keeps the request queue from overflowing
    assert_req_no_overflow_R2: assert property (@(posedge clk) disable iff (rst)
        req_push |-> !req_full);
    // A taken refusal yields a pending NACK next cycle
    assert_nack_after_refusal_R3: assert property (@(posedge clk) disable iff (rst)
        (is_req && in_accept && !src_room) |=> nack_valid);
    // Replies are never back-pressured
    assert_reply_accepted_R6: assert property (@(posedge clk) disable iff (rst)
        is_rep |-> in_accept);
    // Overflow flag is sticky
    assert_err_sticky_R7: assert property (@(posedge clk) disable iff (rst)
        rep_overflow_err |=> rep_overflow_err);
    // Self-originated requests never reach the request queue
    assert_self_refused_R4: assert property (@(posedge clk) disable iff (rst)
        (is_req && int'(in_src) == SELF_ID) |-> !req_push);

endmodule

// File: tb/rsv_inbuf_admit_tb_top.sv
module rsv_inbuf_admit_tb_top;
    localparam int NODES = 4, K = 2, PW = 8, TAGW = 4, SW = 2;

    logic clk = 1'b0, rst = 1'b1;
    logic in_valid = 0, in_is_reply = 0, nack_ready = 0, req_deq_ready = 0, rep_deq_ready = 0;
    logic [SW-1:0] in_src = '0;
    logic [TAGW-1:0] in_tag = '0;
    logic [PW-1:0] in_payload = '0;
    logic in_accept, nack_valid, credit_valid, req_deq_valid, rep_deq_valid, rep_overflow_err;
    logic [SW-1:0] nack_src, credit_src, req_deq_src, rep_deq_src;
    logic [TAGW-1:0] nack_tag, req_deq_tag, rep_deq_tag;
    logic [PW-1:0] req_deq_payload, rep_deq_payload;

    int checks = 0, failures = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    rsv_inbuf_admit #(.NODES(NODES), .K(K), .PW(PW), .TAGW(TAGW), .SELF_ID(0), .NACK_DEPTH(2)) dut_i (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_is_reply(in_is_reply),
        .in_src(in_src), .in_tag(in_tag), .in_payload(in_payload), .in_accept(in_accept),
        .nack_valid(nack_valid), .nack_ready(nack_ready), .nack_src(nack_src), .nack_tag(nack_tag),
        .credit_valid(credit_valid), .credit_src(credit_src),
        .req_deq_valid(req_deq_valid), .req_deq_ready(req_deq_ready), .req_deq_src(req_deq_src),
        .req_deq_tag(req_deq_tag), .req_deq_payload(req_deq_payload),
        .rep_deq_valid(rep_deq_valid), .rep_deq_ready(rep_deq_ready), .rep_deq_src(rep_deq_src),
        .rep_deq_tag(rep_deq_tag), .rep_deq_payload(rep_deq_payload),
        .rep_overflow_err(rep_overflow_err)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Present one transaction for one cycle; returns in_accept seen in that cycle
    task automatic send(input bit rep, input int src, input int tag, input int pl, output bit acc);
        in_valid = 1; in_is_reply = rep; in_src = SW'(src); in_tag = TAGW'(tag); in_payload = PW'(pl);
        #1 acc = in_accept;
        @(negedge clk);
        in_valid = 0;
        #1;
    endtask

    task automatic pop_req(output int src, output int tag, output bit cv, output int cs);
        req_deq_ready = 1;
        #0.5 src = req_deq_src; tag = req_deq_tag; cv = credit_valid; cs = credit_src;
        @(negedge clk);
        req_deq_ready = 0;
        #1;
    endtask

    task automatic pop_nack(output int src, output int tag);
        nack_ready = 1;
        #0.5 src = nack_src; tag = nack_tag;
        @(negedge clk);
        nack_ready = 0;
        #1;
    endtask

    task automatic t_reset();
        chk("R1", "req_deq_valid", req_deq_valid, 0);
        chk("R1", "rep_deq_valid", rep_deq_valid, 0);
        chk("R1", "nack_valid", nack_valid, 0);
        chk("R1", "rep_overflow_err", rep_overflow_err, 0);
        chk("R1", "in_accept", in_accept, 1);
    endtask

    task automatic t_req_order();
        bit a, cv; int s, t, cs;
        send(0, 1, 3, 8'hA5, a);
        chk("R2", "accept", a, 1);
        chk("R2", "deq valid", req_deq_valid, 1);
        chk("R2", "head src", req_deq_src, 1);
        chk("R2", "head tag", req_deq_tag, 3);
        chk("R2", "head payload", req_deq_payload, 8'hA5);
        send(0, 2, 4, 8'h11, a);
        chk("R2", "head unchanged", req_deq_src, 1);
        pop_req(s, t, cv, cs);
        chk("R5", "credit pulse", cv, 1);
        chk("R5", "credit src", cs, 1);
        chk("R5", "credit idle after", credit_valid, 0);
        chk("R2", "second in order", req_deq_tag, 4);
        pop_req(s, t, cv, cs);
        chk("R5", "credit src 2", cs, 2);
        chk("R2", "queue empty", req_deq_valid, 0);
    endtask

    task automatic t_share_nack();
        bit a, cv; int s, t, cs;
        send(0, 3, 1, 1, a);
        send(0, 3, 2, 2, a);
        send(0, 3, 7, 3, a);
        chk("R3", "refused request taken", a, 1);
        chk("R3", "nack valid", nack_valid, 1);
        chk("R3", "nack src", nack_src, 3);
        chk("R3", "nack tag", nack_tag, 7);
        pop_nack(s, t);
        chk("R3", "nack drained", nack_valid, 0);
        pop_req(s, t, cv, cs);
        chk("R3", "first kept", t, 1);
        send(0, 3, 9, 4, a);
        chk("R5", "refill after credit no nack", nack_valid, 0);
        pop_req(s, t, cv, cs);
        chk("R3", "second kept", t, 2);
        pop_req(s, t, cv, cs);
        chk("R5", "refilled entry", t, 9);
        chk("R3", "refused not enqueued", req_deq_valid, 0);
    endtask

    task automatic t_self();
        bit a; int s, t;
        send(0, 0, 5, 0, a);
        chk("R4", "self nack", nack_valid, 1);
        chk("R4", "self nack src", nack_src, 0);
        chk("R4", "self not enqueued", req_deq_valid, 0);
        pop_nack(s, t);
    endtask

    task automatic t_nack_full();
        bit a, cv; int s, t, cs;
        send(0, 3, 1, 0, a);
        send(0, 3, 2, 0, a);
        send(0, 3, 5, 0, a);
        send(0, 3, 6, 0, a);
        send(0, 3, 7, 0, a);
        chk("R8", "stall when nack queue full", a, 0);
        pop_nack(s, t);
        chk("R8", "nack order 1", t, 5);
        pop_nack(s, t);
        chk("R8", "nack order 2", t, 6);
        chk("R8", "stalled request not consumed", nack_valid, 0);
        pop_req(s, t, cv, cs);
        pop_req(s, t, cv, cs);
        chk("R8", "req queue drained", req_deq_valid, 0);
    endtask

    task automatic t_reply();
        bit a, cv; int s, t, cs;
        for (int n = 1; n < NODES; n++) begin
            send(0, n, n, 0, a);
            send(0, n, n + 8, 0, a);
        end
        send(1, 2, 9, 8'h3C, a);
        chk("R6", "reply accepted with req queue full", a, 1);
        chk("R6", "reply visible", rep_deq_valid, 1);
        chk("R6", "reply payload", rep_deq_payload, 8'h3C);
        chk("R6", "reply src", rep_deq_src, 2);
        send(1, 1, 10, 8'h44, a);
        chk("R7", "no error at K", rep_overflow_err, 0);
        send(1, 3, 11, 8'h55, a);
        chk("R6", "accept when reply full", a, 1);
        chk("R7", "error set", rep_overflow_err, 1);
        rep_deq_ready = 1; #0.5 t = rep_deq_tag; @(negedge clk); #1;
        chk("R7", "reply 1 tag", t, 9);
        #0.5 t = rep_deq_tag; @(negedge clk); rep_deq_ready = 0; #1;
        chk("R7", "reply 2 tag", t, 10);
        chk("R7", "overflow reply dropped", rep_deq_valid, 0);
        chk("R7", "error sticky", rep_overflow_err, 1);
        chk("R9", "req head unchanged", req_deq_tag, 1);
        chk("R9", "req still valid", req_deq_valid, 1);
        for (int n = 0; n < 6; n++) pop_req(s, t, cv, cs);
        chk("R9", "req drained", req_deq_valid, 0);
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            checks++; failures++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        #1;
        t_reset();
        t_req_order();
        t_share_nack();
        t_self();
        t_nack_full();
        t_reply();
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule